// File: doc/BRIEF.md
# PCI Target Transaction Controller

This block runs the target side of a 32-bit PCI agent. When the bus starts a transaction it records the command nibble and the address-hit verdict, places the command in one of four groups (read, write, configuration, not claimed) and then drives the three target control lines through every data phase until the master finishes. Read-type commands are answered with data on every phase. Configuration commands complete exactly one word and then disconnect.

Write-type commands are posted. Every word that moves on the bus is pushed, with its byte enables, into a write FIFO owned by the user logic. When that FIFO reports full, a policy input chooses what happens. In one setting the target disconnects at once and moves no data. In the other it holds the bus in wait states for a bounded number of clocks and disconnects if space still has not appeared. A status output tells the user side that posted write data is still outstanding.

Address decoding, parity, configuration register contents and master operation lie outside the block. The address-hit input stands in for the decoder, and the reset input is expected to be released synchronously by the reset tree.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: The command nibble sampled at the address phase is grouped as follows. 0110, 1100 and 1110 are reads. 0111 and 1111 are writes. 1010 and 1011 are configuration accesses. Every other code, including the reserved codes 1000 and 1001, is never claimed: devsel_n stays 1 for the whole transaction.
- R2: A transaction is claimed only when addr_hit is 1 at the address phase, which is the rising edge at which frame_n is first sampled low while the controller is idle. Without the hit, devsel_n, trdy_n and stop_n stay 1.
- R3: If the address phase is sampled at edge k, devsel_n is 1 after edge k and goes to 0 after edge k+1 (medium decode).
- R4: For a read, every data phase has trdy_n=0 and stop_n=1 while devsel_n=0, so bursts of any length complete.
- R5: For a write, in every cycle with irdy_n=0 and trdy_n=0, fifo_push is 1 in that same cycle. fifo_data carries ad and fifo_be carries the byte enables in active-high form (~cbe_n).
- R6: During a write, trdy_n is 1 in any cycle in which fifo_full is 1, so no word is pushed into a full FIFO. Configuration and read phases never push.
- R7: With full_disc=1, a write data phase that meets fifo_full=1 shows stop_n=0 and trdy_n=1 in that same cycle (disconnect without data).
- R8: With full_disc=0, a full FIFO produces at most 8 wait cycles (trdy_n=1, stop_n=1). If fifo_full clears within them, the word is accepted with trdy_n=0 and the counter restarts for the next phase. If fifo_full is still 1 in the ninth cycle, that cycle shows stop_n=0 and trdy_n=1.
- R9: A configuration access completes its first data phase with trdy_n=0 and stop_n=0 together. Every later cycle of that transaction shows trdy_n=1 and stop_n=0.
- R10: Once stop_n has been 0 at a clock edge within a transaction, trdy_n stays 1 and stop_n stays 0 until that transaction ends, even if fifo_full clears.
- R11: A transaction ends at the edge where frame_n=1, irdy_n=0 and either trdy_n or stop_n is 0. In the next cycle devsel_n, trdy_n and stop_n are all 1 (turnaround), and one cycle later the controller can take a new address phase.
- R12: wr_busy becomes 1 at the edge after any push. It returns to 0 at the first edge at which the controller is idle and fifo_empty is 1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| frame_n | input | 1 | Master frame, active low |
| irdy_n | input | 1 | Master ready, active low |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad | input | DATA_W | Bus data during data phases |
| addr_hit | input | 1 | Address decoder verdict for the current address phase |
| full_disc | input | 1 | FIFO-full policy: 1 disconnects at once, 0 waits up to WAIT_MAX clocks |
| fifo_full | input | 1 | Write FIFO cannot accept a word this cycle |
| fifo_empty | input | 1 | Write FIFO has been drained by the user logic |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| fifo_push | output | 1 | Write one word into the FIFO this cycle |
| fifo_data | output | DATA_W | Word to write |
| fifo_be | output | DATA_W/8 | Active-high byte enables for that word |
| wr_busy | output | 1 | Posted write data still outstanding |

## Verification
The three control lines and fifo_push are combinational functions of the registered state and the current fifo_full and irdy_n. They are therefore due in the same cycle as the inputs that the bench drives on the falling edge, and the bench reads them one time unit later, before the next rising edge. Decode latency is two registers: after the address-phase edge, the bench checks the DEC cycle with devsel_n high and then the following cycle with devsel_n low. wr_busy and the turnaround state are one register away, so they are checked in the cycle after the push or after the final completion edge. Each wait-state scenario counts its cycles from the first full data phase, so the bench knows the exact cycle in which stop_n must fall.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    CLS_IGN = 2'd0,
    CLS_RD  = 2'd1,
    CLS_WR  = 2'd2,
    CLS_CFG = 2'd3
  } cmd_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_DATA = 3'd2,
    ST_TURN = 3'd3,
    ST_SKIP = 3'd4
  } tgt_st_e;

  // Cache-line read/write variants collapse onto the plain read/write group.
  function automatic cmd_cls_e classify_cmd(input logic [3:0] cmd);
    cmd_cls_e cls;
    case (cmd)
      4'b0110, 4'b1100, 4'b1110: cls = CLS_RD;
      4'b0111, 4'b1111:          cls = CLS_WR;
      4'b1010, 4'b1011:          cls = CLS_CFG;
      default:                   cls = CLS_IGN;
    endcase
    return cls;
  endfunction

endpackage

// File: rtl/pci_cmd_latch.sv
module pci_cmd_latch
  import pci_tgt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  logic [3:0] cmd,
  input  logic     hit,
  output logic     claim,
  output cmd_cls_e cls_q
);

  cmd_cls_e cls_now;
  cmd_cls_e cls_d;

  always_comb begin
    cls_now = classify_cmd(cmd);
    claim   = hit && (cls_now != CLS_IGN);
  end

  // Clock enable: hold the group between address phases.
  always_comb begin
    cls_d = cls_q;
    if (capture) begin
      cls_d = claim ? cls_now : CLS_IGN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= CLS_IGN;
    end else begin
      cls_q <= cls_d;
    end
  end

  AST_CLAIM_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !hit) |=> (cls_q == CLS_IGN)); // R2

endmodule

// File: rtl/pci_wr_throttle.sv
module pci_wr_throttle #(
  parameter int WAIT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  input  logic clr,
  output logic at_limit
);

  localparam int CNT_W = $clog2(WAIT_MAX + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    at_limit = (cnt_q == LIMIT);
    cnt_d    = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (stall && !at_limit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !clr) |=> (cnt_q != '0)); // R8

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
  import pci_tgt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_n,
  input  logic     irdy_n,
  input  logic     claim,
  input  cmd_cls_e cls,
  input  logic     fifo_full,
  input  logic     full_disc,
  input  logic     at_limit,
  output logic     capture,
  output logic     stall,
  output logic     cnt_clr,
  output logic     idle,
  output logic     push,
  output logic     devsel_n,
  output logic     trdy_n,
  output logic     stop_n
);

  tgt_st_e state_q;
  tgt_st_e state_d;
  logic    disc_q;
  logic    disc_d;
  logic    in_data;
  logic    xfer_end;

  always_comb begin
    in_data  = (state_q == ST_DATA);
    idle     = (state_q == ST_IDLE);
    capture  = idle && !frame_n;
    devsel_n = 1'b1;
    trdy_n   = 1'b1;
    stop_n   = 1'b1;
    stall    = 1'b0;
    if (in_data) begin
      devsel_n = 1'b0;
      if (disc_q) begin
        stop_n = 1'b0;
      end else begin
        case (cls)
          CLS_RD: trdy_n = 1'b0;
          CLS_CFG: begin
            trdy_n = 1'b0;
            stop_n = 1'b0;
          end
          CLS_WR: begin
            trdy_n = fifo_full;
            if (fifo_full && (full_disc || at_limit)) begin
              stop_n = 1'b0;
            end else if (fifo_full) begin
              stall = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
    push     = in_data && (cls == CLS_WR) && !irdy_n && !trdy_n;
    xfer_end = in_data && !irdy_n && (!trdy_n || !stop_n);
    cnt_clr  = !in_data || (!irdy_n && !trdy_n);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (!frame_n) state_d = claim ? ST_DEC : ST_SKIP;
      ST_DEC:  state_d = ST_DATA;
      ST_DATA: if (xfer_end && frame_n) state_d = ST_TURN;
      ST_TURN: state_d = ST_IDLE;
      ST_SKIP: if (frame_n && irdy_n) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    disc_d = in_data && (state_d == ST_DATA) && (disc_q || !stop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      disc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      disc_q  <= disc_d;
    end
  end

  AST_DEVSEL_MEDIUM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> ($past(state_q) == ST_DEC)); // R3
  AST_CTRL_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n || !stop_n) |-> !devsel_n); // R4
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full); // R6
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !stop_n && !(xfer_end && frame_n)) |=> (trdy_n && !stop_n)); // R10
  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && frame_n) |=> (devsel_n && trdy_n && stop_n)); // R11
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |=> (devsel_n || $past(state_q) != ST_SKIP)); // R1

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WAIT_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [3:0]        cbe_n,
  input  logic [DATA_W-1:0] ad,
  input  logic              addr_hit,
  input  logic              full_disc,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_data,
  output logic [DATA_W/8-1:0] fifo_be,
  output logic              wr_busy
);

  localparam int BE_W = DATA_W / 8;

  logic     claim;
  cmd_cls_e cls_q;
  logic     capture;
  logic     stall;
  logic     cnt_clr;
  logic     at_limit;
  logic     idle;
  logic     push;
  logic     busy_d;

  pci_cmd_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .cmd     (cbe_n),
    .hit     (addr_hit),
    .claim   (claim),
    .cls_q   (cls_q)
  );

  pci_wr_throttle #(.WAIT_MAX(WAIT_MAX)) u_throttle (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .clr      (cnt_clr),
    .at_limit (at_limit)
  );

  pci_tgt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .claim     (claim),
    .cls       (cls_q),
    .fifo_full (fifo_full),
    .full_disc (full_disc),
    .at_limit  (at_limit),
    .capture   (capture),
    .stall     (stall),
    .cnt_clr   (cnt_clr),
    .idle      (idle),
    .push      (push),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n)
  );

  always_comb begin
    fifo_push = push;
    fifo_data = ad;
    fifo_be   = ~cbe_n[BE_W-1:0];
    busy_d    = wr_busy;
    if (push) begin
      busy_d = 1'b1;
    end else if (idle && fifo_empty) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_busy <= 1'b0;
    end else begin
      wr_busy <= busy_d;
    end
  end

  AST_BUSY_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |=> wr_busy); // R12
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && !fifo_empty) |=> wr_busy); // R12

endmodule

// File: tb/tb_pci_tgt_ctrl.sv
module tb_pci_tgt_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, addr_hit, full_disc, fifo_full, fifo_empty;
  logic [3:0]  cbe_n;
  logic [31:0] ad;
  logic        devsel_n, trdy_n, stop_n, fifo_push, wr_busy;
  logic [31:0] fifo_data;
  logic [3:0]  fifo_be;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_tgt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad(ad), .addr_hit(addr_hit), .full_disc(full_disc),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .fifo_push(fifo_push),
    .fifo_data(fifo_data), .fifo_be(fifo_be), .wr_busy(wr_busy)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_bus(string req, logic dv, logic tr, logic st);
    #1;
    chk(req, "devsel_n", devsel_n, dv);
    chk(req, "trdy_n", trdy_n, tr);
    chk(req, "stop_n", stop_n, st);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(logic f, logic i, logic [3:0] c);
    frame_n = f;
    irdy_n  = i;
    cbe_n   = c;
  endtask

  // Address phase; returns at the negedge of the cycle after it (DEC/SKIP).
  task automatic bus_start(logic [3:0] cmd, logic hit);
    drive(1'b0, 1'b1, cmd);
    addr_hit = hit;
    tick();
    addr_hit = 1'b0;
  endtask

  task automatic bus_idle();
    drive(1'b1, 1'b1, 4'hF);
    tick();
  endtask

  task automatic t_reset();
    #1;
    chk("R11", "reset devsel_n", devsel_n, 1'b1);
    chk("R11", "reset trdy_n", trdy_n, 1'b1);
    chk("R11", "reset stop_n", stop_n, 1'b1);
    chk("R12", "reset wr_busy", wr_busy, 1'b0);
    chk("R5", "reset fifo_push", fifo_push, 1'b0);
  endtask

  task automatic t_read_burst(logic [3:0] cmd);
    bus_start(cmd, 1'b1);
    drive(1'b0, 1'b0, 4'h0);
    expect_bus("R3", 1'b1, 1'b1, 1'b1);
    tick();
    expect_bus("R4", 1'b0, 1'b0, 1'b1);
    chk("R6", "read push", fifo_push, 1'b0);
    tick();
    drive(1'b1, 1'b0, 4'h0);
    expect_bus("R4", 1'b0, 1'b0, 1'b1);
    tick();
    drive(1'b1, 1'b1, 4'hF);
    expect_bus("R11", 1'b1, 1'b1, 1'b1);
    tick();
  endtask

  task automatic t_unclaimed(logic [3:0] cmd, logic hit, string req);
    bus_start(cmd, hit);
    drive(1'b0, 1'b0, 4'h0);
    expect_bus(req, 1'b1, 1'b1, 1'b1);
    tick();
    expect_bus(req, 1'b1, 1'b1, 1'b1);
    tick();
    drive(1'b1, 1'b0, 4'h0);
    expect_bus(req, 1'b1, 1'b1, 1'b1);
    tick();
    bus_idle();
  endtask

  task automatic t_write_burst();
    fifo_empty = 1'b0;
    full_disc  = 1'b0;
    bus_start(4'b0111, 1'b1);
    drive(1'b0, 1'b0, 4'b0101);
    ad = 32'hA5A5_0001;
    expect_bus("R3", 1'b1, 1'b1, 1'b1);
    chk("R5", "push in decode", fifo_push, 1'b0);
    tick();
    expect_bus("R5", 1'b0, 1'b0, 1'b1);
    chk("R5", "push word1", fifo_push, 1'b1);
    chk("R5", "data word1", fifo_data, 32'hA5A5_0001);
    chk("R5", "be word1", fifo_be, 4'b1010);
    tick();
    chk("R12", "busy after push", wr_busy, 1'b1);
    drive(1'b1, 1'b0, 4'b0000);
    ad = 32'h1234_5678;
    expect_bus("R5", 1'b0, 1'b0, 1'b1);
    chk("R5", "push word2", fifo_push, 1'b1);
    chk("R5", "data word2", fifo_data, 32'h1234_5678);
    chk("R5", "be word2", fifo_be, 4'b1111);
    tick();
    drive(1'b1, 1'b1, 4'hF);
    expect_bus("R11", 1'b1, 1'b1, 1'b1);
    chk("R5", "no push in turnaround", fifo_push, 1'b0);
    tick();
    tick();
    chk("R12", "busy held until drained", wr_busy, 1'b1);
    fifo_empty = 1'b1;
    tick();
    chk("R12", "busy cleared", wr_busy, 1'b0);
  endtask

  task automatic t_write_inval();
    bus_start(4'b1111, 1'b1);
    drive(1'b1, 1'b0, 4'b0000);
    ad = 32'hCAFE_F00D;
    tick();
    expect_bus("R1", 1'b0, 1'b0, 1'b1);
    chk("R1", "invalidate push", fifo_push, 1'b1);
    tick();
    expect_bus("R11", 1'b1, 1'b1, 1'b1);
    tick();
  endtask

  task automatic t_full_disconnect();
    full_disc = 1'b1;
    bus_start(4'b0111, 1'b1);
    drive(1'b0, 1'b0, 4'h0);
    tick();
    fifo_full = 1'b1;
    expect_bus("R7", 1'b0, 1'b1, 1'b0);
    chk("R6", "no push when full", fifo_push, 1'b0);
    tick();
    fifo_full = 1'b0;
    drive(1'b1, 1'b0, 4'h0);
    expect_bus("R10", 1'b0, 1'b1, 1'b0);
    chk("R10", "no push after stop", fifo_push, 1'b0);
    tick();
    drive(1'b1, 1'b1, 4'hF);
    expect_bus("R11", 1'b1, 1'b1, 1'b1);
    tick();
    full_disc = 1'b0;
  endtask

  task automatic t_wait_limit();
    full_disc = 1'b0;
    bus_start(4'b0111, 1'b1);
    drive(1'b0, 1'b0, 4'h0);
    tick();
    fifo_full = 1'b1;
    for (int w = 0; w < 8; w++) begin
      expect_bus("R8", 1'b0, 1'b1, 1'b1);
      tick();
    end
    expect_bus("R8", 1'b0, 1'b1, 1'b0);
    tick();
    fifo_full = 1'b0;
    drive(1'b1, 1'b0, 4'h0);
    expect_bus("R10", 1'b0, 1'b1, 1'b0);
    tick();
    drive(1'b1, 1'b1, 4'hF);
    expect_bus("R11", 1'b1, 1'b1, 1'b1);
    tick();
  endtask

  task automatic t_wait_recover();
    full_disc = 1'b0;
    bus_start(4'b0111, 1'b1);
    drive(1'b0, 1'b0, 4'h0);
    tick();
    fifo_full = 1'b1;
    for (int w = 0; w < 5; w++) begin
      expect_bus("R8", 1'b0, 1'b1, 1'b1);
      tick();
    end
    fifo_full = 1'b0;
    expect_bus("R8", 1'b0, 1'b0, 1'b1);
    chk("R8", "push after space", fifo_push, 1'b1);
    tick();
    // counter restarted: another 8 waits allowed on the next word
    fifo_full = 1'b1;
    for (int w = 0; w < 8; w++) begin
      expect_bus("R8", 1'b0, 1'b1, 1'b1);
      tick();
    end
    fifo_full = 1'b0;
    drive(1'b1, 1'b0, 4'h0);
    expect_bus("R8", 1'b0, 1'b0, 1'b1);
    tick();
    drive(1'b1, 1'b1, 4'hF);
    expect_bus("R11", 1'b1, 1'b1, 1'b1);
    tick();
  endtask

  task automatic t_config(logic [3:0] cmd);
    bus_start(cmd, 1'b1);
    drive(1'b0, 1'b0, 4'h0);
    tick();
    expect_bus("R9", 1'b0, 1'b0, 1'b0);
    chk("R6", "config push", fifo_push, 1'b0);
    tick();
    drive(1'b0, 1'b0, 4'h0);
    expect_bus("R9", 1'b0, 1'b1, 1'b0);
    tick();
    drive(1'b1, 1'b0, 4'h0);
    expect_bus("R9", 1'b0, 1'b1, 1'b0);
    tick();
    drive(1'b1, 1'b1, 4'hF);
    expect_bus("R11", 1'b1, 1'b1, 1'b1);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad = '0;
    addr_hit = 1'b0; full_disc = 1'b0; fifo_full = 1'b0; fifo_empty = 1'b1;
    tick();
    t_reset();
    tick();
    rst_n = 1'b1;
    tick();
    t_read_burst(4'b0110);
    t_read_burst(4'b1100);
    t_read_burst(4'b1110);
    t_unclaimed(4'b1000, 1'b1, "R1");
    t_unclaimed(4'b1001, 1'b1, "R1");
    t_unclaimed(4'b0010, 1'b1, "R1");
    t_unclaimed(4'b0110, 1'b0, "R2");
    t_write_burst();
    t_write_inval();
    t_full_disconnect();
    t_wait_limit();
    t_wait_recover();
    t_config(4'b1010);
    t_config(4'b1011);
    t_read_burst(4'b0110);
    finish_run();
  end

endmodule